// File: doc/BRIEF.md
# Display Adapter Register Window Decoder

This block sits behind a 4 KiB memory-mapped register aperture of a display adapter. It decodes every bus access and steers it to one of three targets. The first is a bank of legacy byte-wide display I/O ports, reached through a remapped range. The second is an indexed file of 16-bit mode registers. The third is an optional small bank that reports its own length and holds the framebuffer byte-order control. Offsets that fall outside all three targets read as zero, and writes to them are dropped.

Halfword accesses to the legacy bank are split into two byte operations on consecutive clock cycles. The lower address always goes first, so an index port is loaded before the data port that depends on it, and both can be set with one bus write. During the second byte the block raises a busy flag, and the requester must not issue a new access while it is high. Read data comes back from a register together with a valid pulse. For a split legacy read the pulse arrives two cycles after the request. For every other read it arrives one cycle after.

Top module: `disp_mmio_window`

## Requirements
- R1: A byte access at window offset 0x400+k (k from 0 to 31) reaches port address 0x3C0+k. A write carries bus_wdata[7:0]. A read returns the port byte in bus_rdata[7:0] with the upper bits zero. port_wr and port_rd are never high together.
- R2: A halfword write (bus_size 1) to the legacy bank writes bus_wdata[7:0] to port P in the request cycle. In the next cycle it writes bus_wdata[15:8] to port P+1. bus_busy is high during that second cycle, and no request may be issued then.
- R3: A halfword read of the legacy bank reads port P, then port P+1 in the next cycle. It returns {byte(P+1), byte(P)} in bus_rdata[15:0], with bus_rvalid two cycles after the request.
- R4: An access of any size at offsets 0x500 to 0x515 drives ext_idx = (offset-0x500)>>1, which stays below 11. A write carries bus_wdata[15:0]. A read returns ext_rdata, zero-extended.
- R5: The byte-order bank at 0x600 to 0x607 answers only word accesses (bus_size 2). Offset 0x600 reads 8. Offset 0x604 reads 0xBEBEBEBE while big_endian is 1 and 0x1E1E1E1E while it is 0.
- R6: A word write of exactly 0xBEBEBEBE to 0x604 sets big_endian. A word write of exactly 0x1E1E1E1E clears it. Any other value, and any non-word access, leaves it unchanged.
- R7: The other offsets of the byte-order bank read 0, and writes to them do not change big_endian.
- R8: Offsets outside all three targets, and legacy accesses of word size, read 0 and produce no port or register write strobe.
- R9: Every read other than a legacy halfword read sets bus_rvalid and bus_rdata one cycle after the request.
- R10: After reset, big_endian, bus_rvalid, bus_busy and bus_rdata are all 0.
- R11: rev_id reads 2 when the byte-order bank is built in (EXT_EN=1) and 1 when it is left out. When it is left out, offset 0x604 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 12 | Window offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_busy | output | 1 | Second phase of a split legacy access |
| port_wr | output | 1 | Legacy port write strobe |
| port_rd | output | 1 | Legacy port read strobe |
| port_addr | output | 10 | Legacy port address |
| port_wdata | output | 8 | Legacy port write byte |
| port_rdata | input | 8 | Legacy port read byte, combinational |
| ext_wr | output | 1 | Mode register write strobe |
| ext_rd | output | 1 | Mode register read strobe |
| ext_idx | output | 4 | Mode register index |
| ext_wdata | output | 16 | Mode register write data |
| ext_rdata | input | 16 | Mode register read data, combinational |
| big_endian | output | 1 | Framebuffer byte-order flag |
| rev_id | output | 8 | Revision identifier |

## Verification
The hardest state to reach is the second phase of a split legacy access. Only a halfword request to the legacy range creates it, and the ordering it enforces cannot be seen from one sample of the port strobes. The bench logs every port write with its address in an ordered list. A halfword write into an index/data pair must leave exactly two entries, lower port first. The bench also checks that busy was high between them. The byte-order flag can only be driven into a set state by one magic word, so the bench sets it first and then sends near-miss values, wrong sizes and hole offsets, each of which must leave it set.

// File: rtl/disp_win_pkg.sv
// Shared types and constants for the display register window.
// Assumes a 12-bit window offset and the size encoding below.
package disp_win_pkg;
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_LEG  = 2'd1,
        RG_EXTR = 2'd2,
        RG_QX   = 2'd3
    } region_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [31:0] MAGIC_BE = 32'hBEBE_BEBE;
    localparam logic [31:0] MAGIC_LE = 32'h1E1E_1E1E;
endpackage

// File: rtl/disp_win_decode.sv
// Address decoder: classifies a window offset and access size into one of
// the targets and computes each target's local offset.
// Assumes targets do not overlap. Sizes a target cannot take map to RG_NONE.
module disp_win_decode
    import disp_win_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit EXT_EN    = 1'b1,
    parameter logic [ADDR_W-1:0] LEG_BASE  = 12'h400,
    parameter int LEG_SPAN  = 32,
    parameter logic [ADDR_W-1:0] EXTR_BASE = 12'h500,
    parameter int EXTR_REGS = 11,
    parameter logic [ADDR_W-1:0] QX_BASE   = 12'h600,
    parameter int QX_SPAN   = 8,
    localparam int LEG_OFF_W = $clog2(LEG_SPAN),
    localparam int IDX_W     = $clog2(EXTR_REGS),
    localparam int QX_OFF_W  = $clog2(QX_SPAN)
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    output region_e             region,
    output logic [LEG_OFF_W-1:0] leg_off,
    output logic [IDX_W-1:0]    ext_idx,
    output logic [QX_OFF_W-1:0] qx_off
);
    localparam logic [ADDR_W-1:0] LEG_LIM  = ADDR_W'(LEG_SPAN);
    localparam logic [ADDR_W-1:0] EXTR_LIM = ADDR_W'(2 * EXTR_REGS);
    localparam logic [ADDR_W-1:0] QX_LIM   = ADDR_W'(QX_SPAN);

    logic [ADDR_W-1:0] rel_leg, rel_ext, rel_qx;
    logic hit_leg, hit_ext, hit_qx;

    // Offsets relative to each target base and range hits.
    always_comb begin
        rel_leg = addr - LEG_BASE;
        rel_ext = addr - EXTR_BASE;
        rel_qx  = addr - QX_BASE;
        hit_leg = (addr >= LEG_BASE) && (rel_leg < LEG_LIM) && (size <= SZ_HALF);
        hit_ext = (addr >= EXTR_BASE) && (rel_ext < EXTR_LIM);
        hit_qx  = EXT_EN && (addr >= QX_BASE) && (rel_qx < QX_LIM) && (size == SZ_WORD);
    end

    // Target selection, with local offsets for the chosen target.
    always_comb begin
        if (hit_leg)      region = RG_LEG;
        else if (hit_ext) region = RG_EXTR;
        else if (hit_qx)  region = RG_QX;
        else              region = RG_NONE;
        leg_off = LEG_OFF_W'(rel_leg);
        ext_idx = IDX_W'(rel_ext >> 1);
        qx_off  = QX_OFF_W'(rel_qx);
    end
endmodule

// File: rtl/disp_legacy_seq.sv
// Legacy byte-port sequencer. Byte accesses complete in one cycle. A
// halfword access is split into the low byte at the addressed port, then
// the high byte at the next port one cycle later.
// Assumes no new request arrives while busy is high.
module disp_legacy_seq #(
    parameter int PORT_W    = 10,
    parameter logic [PORT_W-1:0] PORT_BASE = 10'h3C0,
    parameter int LEG_OFF_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 we,
    input  logic                 half,
    input  logic [LEG_OFF_W-1:0] off,
    input  logic [15:0]          wdata,
    output logic                 port_wr,
    output logic                 port_rd,
    output logic [PORT_W-1:0]    port_addr,
    output logic [7:0]           port_wdata,
    input  logic [7:0]           port_rdata,
    output logic                 busy,
    output logic                 rd_done,
    output logic [15:0]          rd_val
);
    logic              ph2_q, ph2_we_q;
    logic [PORT_W-1:0] ph2_addr_q;
    logic [7:0]        ph2_data_q, lo_q;
    logic              start;
    logic [PORT_W-1:0] first_addr;

    // A new access is accepted only outside the second phase.
    always_comb begin
        start      = sel && !ph2_q;
        first_addr = PORT_BASE + PORT_W'(off);
    end

    // Drive the port strobes for the current phase.
    always_comb begin
        port_wr    = 1'b0;
        port_rd    = 1'b0;
        port_addr  = first_addr;
        port_wdata = wdata[7:0];
        rd_done    = 1'b0;
        rd_val     = {8'h00, port_rdata};
        if (ph2_q) begin
            port_addr  = ph2_addr_q;
            port_wdata = ph2_data_q;
            port_wr    = ph2_we_q;
            port_rd    = !ph2_we_q;
            rd_done    = !ph2_we_q;
            rd_val     = {port_rdata, lo_q};
        end else if (start) begin
            port_wr = we;
            port_rd = !we;
            rd_done = !we && !half;
        end
    end

    // Hold the second half of a split access for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph2_q      <= 1'b0;
            ph2_we_q   <= 1'b0;
            ph2_addr_q <= '0;
            ph2_data_q <= '0;
            lo_q       <= '0;
        end else begin
            ph2_q <= start && half;
            if (start) begin
                ph2_we_q   <= we;
                ph2_addr_q <= first_addr + PORT_W'(1);
                ph2_data_q <= wdata[15:8];
                lo_q       <= port_rdata;
            end
        end
    end

    assign busy = ph2_q;

    AST_SPLIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (start && we && half) |=> (port_wr && port_addr == $past(port_addr) + PORT_W'(1))); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr && port_rd)); // R1
    AST_SPLIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !we && half) |=> (port_rd && rd_done)); // R3
endmodule

// File: rtl/disp_qx_bank.sv
// Optional byte-order bank: offset 0 reports the bank length, offset 4
// holds the framebuffer byte-order flag, which changes only on magic words.
// When EXT_EN is 0 no state is built and the flag stays little-endian.
module disp_qx_bank
    import disp_win_pkg::*;
#(
    parameter bit EXT_EN   = 1'b1,
    parameter int QX_SPAN  = 8,
    localparam int QX_OFF_W = $clog2(QX_SPAN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                we,
    input  logic [QX_OFF_W-1:0] off,
    input  logic [31:0]         wdata,
    output logic                big_endian,
    output logic [31:0]         rd_val
);
    localparam logic [QX_OFF_W-1:0] OFF_LEN   = QX_OFF_W'(0);
    localparam logic [QX_OFF_W-1:0] OFF_ORDER = QX_OFF_W'(4);

    generate
        if (EXT_EN) begin : g_bank
            logic be_q;

            // Byte-order flag: set or cleared only by the exact magic words.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    be_q <= 1'b0;
                end else if (sel && we && off == OFF_ORDER) begin
                    if (wdata == MAGIC_BE)      be_q <= 1'b1;
                    else if (wdata == MAGIC_LE) be_q <= 1'b0;
                end
            end

            // Read value for the two defined offsets; holes read zero.
            always_comb begin
                case (off)
                    OFF_LEN:   rd_val = 32'(QX_SPAN);
                    OFF_ORDER: rd_val = be_q ? MAGIC_BE : MAGIC_LE;
                    default:   rd_val = 32'h0;
                endcase
            end

            assign big_endian = be_q;

            AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(sel && we && off == OFF_ORDER && (wdata == MAGIC_BE || wdata == MAGIC_LE))
                |=> $stable(big_endian)); // R6
        end else begin : g_none
            assign big_endian = 1'b0;
            assign rd_val     = 32'h0;
        end
    endgenerate
endmodule

// File: rtl/disp_mmio_window.sv
// Display adapter register window: decodes the aperture, sequences legacy
// port accesses, forwards indexed mode-register accesses and hosts the
// optional byte-order bank. Read data is registered with a valid pulse.
// Assumes the requester honours bus_busy.
module disp_mmio_window
    import disp_win_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PORT_W    = 10,
    parameter bit EXT_EN    = 1'b1,
    parameter logic [ADDR_W-1:0] LEG_BASE  = 12'h400,
    parameter int LEG_SPAN  = 32,
    parameter logic [PORT_W-1:0] PORT_BASE = 10'h3C0,
    parameter logic [ADDR_W-1:0] EXTR_BASE = 12'h500,
    parameter int EXTR_REGS = 11,
    parameter logic [ADDR_W-1:0] QX_BASE   = 12'h600,
    parameter int QX_SPAN   = 8,
    localparam int IDX_W    = $clog2(EXTR_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_busy,
    output logic              port_wr,
    output logic              port_rd,
    output logic [PORT_W-1:0] port_addr,
    output logic [7:0]        port_wdata,
    input  logic [7:0]        port_rdata,
    output logic              ext_wr,
    output logic              ext_rd,
    output logic [IDX_W-1:0]  ext_idx,
    output logic [15:0]       ext_wdata,
    input  logic [15:0]       ext_rdata,
    output logic              big_endian,
    output logic [7:0]        rev_id
);
    localparam int LEG_OFF_W = $clog2(LEG_SPAN);
    localparam int QX_OFF_W  = $clog2(QX_SPAN);
    localparam logic [7:0] REV = EXT_EN ? 8'd2 : 8'd1;

    region_e              region;
    logic [LEG_OFF_W-1:0] leg_off;
    logic [QX_OFF_W-1:0]  qx_off;
    logic                 acc, leg_done;
    logic [15:0]          leg_val;
    logic [31:0]          qx_val;
    logic                 rd_done;
    logic [31:0]          rd_val;

    disp_win_decode #(
        .ADDR_W(ADDR_W), .EXT_EN(EXT_EN),
        .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
        .EXTR_BASE(EXTR_BASE), .EXTR_REGS(EXTR_REGS),
        .QX_BASE(QX_BASE), .QX_SPAN(QX_SPAN)
    ) u_decode (
        .addr(bus_addr), .size(bus_size), .region(region),
        .leg_off(leg_off), .ext_idx(ext_idx), .qx_off(qx_off)
    );

    // Accesses are taken only outside a split legacy second phase.
    assign acc = bus_req && !bus_busy;

    disp_legacy_seq #(
        .PORT_W(PORT_W), .PORT_BASE(PORT_BASE), .LEG_OFF_W(LEG_OFF_W)
    ) u_legacy (
        .clk(clk), .rst_n(rst_n),
        .sel(acc && region == RG_LEG), .we(bus_we), .half(bus_size == SZ_HALF),
        .off(leg_off), .wdata(bus_wdata[15:0]),
        .port_wr(port_wr), .port_rd(port_rd), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .busy(bus_busy), .rd_done(leg_done), .rd_val(leg_val)
    );

    disp_qx_bank #(
        .EXT_EN(EXT_EN), .QX_SPAN(QX_SPAN)
    ) u_qx (
        .clk(clk), .rst_n(rst_n),
        .sel(acc && region == RG_QX), .we(bus_we), .off(qx_off),
        .wdata(bus_wdata), .big_endian(big_endian), .rd_val(qx_val)
    );

    // Mode-register strobes: index from the decoder, data from the low half.
    always_comb begin
        ext_wr    = acc && region == RG_EXTR && bus_we;
        ext_rd    = acc && region == RG_EXTR && !bus_we;
        ext_wdata = bus_wdata[15:0];
    end

    // Pick the read value and decide whether a read completes this cycle.
    always_comb begin
        rd_done = leg_done || (acc && !bus_we && region != RG_LEG);
        if (leg_done) begin
            rd_val = {16'h0, leg_val};
        end else begin
            case (region)
                RG_EXTR: rd_val = {16'h0, ext_rdata};
                RG_QX:   rd_val = qx_val;
                default: rd_val = 32'h0;
            endcase
        end
    end

    // Register read data and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= 32'h0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_done;
            if (rd_done) bus_rdata <= rd_val;
        end
    end

    assign rev_id = REV;

    AST_NO_REQ_IN_PHASE2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> !bus_req); // R2
    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !bus_we && !(region == RG_LEG && bus_size == SZ_HALF)) |=> bus_rvalid); // R9
    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && region == RG_NONE) |-> (!port_wr && !port_rd && !ext_wr && !ext_rd)); // R8
    AST_EXT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr || ext_rd) |-> (ext_idx < IDX_W'(EXTR_REGS))); // R4
endmodule

// File: tb/disp_mmio_window_bench.sv
module disp_mmio_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [11:0] bus_addr = 12'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_busy;
    logic        port_wr, port_rd;
    logic [9:0]  port_addr;
    logic [7:0]  port_wdata, port_rdata;
    logic        ext_wr, ext_rd;
    logic [3:0]  ext_idx;
    logic [15:0] ext_wdata, ext_rdata;
    logic        big_endian;
    logic [7:0]  rev_id;

    // second instance without the byte-order bank
    logic [31:0] n_rdata;
    logic        n_rvalid, n_busy, n_pwr, n_prd, n_ewr, n_erd, n_be;
    logic [9:0]  n_paddr;
    logic [7:0]  n_pwdata, n_rev;
    logic [3:0]  n_eidx;
    logic [15:0] n_ewdata;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    disp_mmio_window u_disp_mmio_window (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_busy(bus_busy),
        .port_wr(port_wr), .port_rd(port_rd), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_idx(ext_idx),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .big_endian(big_endian), .rev_id(rev_id)
    );

    disp_mmio_window #(.EXT_EN(1'b0)) u_noext (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(n_rdata), .bus_rvalid(n_rvalid), .bus_busy(n_busy),
        .port_wr(n_pwr), .port_rd(n_prd), .port_addr(n_paddr),
        .port_wdata(n_pwdata), .port_rdata(8'h00),
        .ext_wr(n_ewr), .ext_rd(n_erd), .ext_idx(n_eidx),
        .ext_wdata(n_ewdata), .ext_rdata(16'h0000),
        .big_endian(n_be), .rev_id(n_rev)
    );

    // storage models for the legacy ports and the mode registers
    logic [7:0]  port_mem [0:63];
    logic [15:0] ext_mem  [0:15];
    logic [9:0]  wlog_addr [0:15];
    logic [7:0]  wlog_data [0:15];
    int wcnt = 0, ecnt = 0;

    assign port_rdata = port_mem[6'(port_addr - 10'h3C0)];
    assign ext_rdata  = ext_mem[ext_idx];

    always @(posedge clk) begin
        if (port_wr) begin
            port_mem[6'(port_addr - 10'h3C0)] <= port_wdata;
            wlog_addr[wcnt[3:0]] <= port_addr;
            wlog_data[wcnt[3:0]] <= port_wdata;
            wcnt <= wcnt + 1;
        end
        if (ext_wr) begin
            ext_mem[ext_idx] <= ext_wdata;
            ecnt <= ecnt + 1;
        end
    end

    task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", r, what, act, exp);
        end
    endtask

    logic seen_busy;

    task automatic bus_write(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        seen_busy = bus_busy;
        if (bus_busy) @(negedge clk);
    endtask

    task automatic bus_read(input logic [1:0] sz, input logic [11:0] a,
                            output logic [31:0] d, output int lat);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_size = sz; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_rvalid && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        d = bus_rdata;
    endtask

    // {we, size, addr, wdata, expected read, requirement}
    localparam int NV = 19;
    localparam logic [82:0] VEC [0:NV-1] = '{
        {1'b1, 2'd0, 12'h403, 32'h0000005A, 32'h0,        4'd1},  // R1
        {1'b0, 2'd0, 12'h403, 32'h0,        32'h0000005A, 4'd1},  // R1
        {1'b1, 2'd1, 12'h404, 32'h0000A711, 32'h0,        4'd2},  // R2
        {1'b0, 2'd1, 12'h404, 32'h0,        32'h0000A711, 4'd3},  // R3
        {1'b0, 2'd0, 12'h405, 32'h0,        32'h000000A7, 4'd2},  // R2
        {1'b1, 2'd1, 12'h508, 32'h0000BEEF, 32'h0,        4'd4},  // R4
        {1'b0, 2'd1, 12'h508, 32'h0,        32'h0000BEEF, 4'd4},  // R4
        {1'b0, 2'd2, 12'h509, 32'h0,        32'h0000BEEF, 4'd4},  // R4
        {1'b0, 2'd2, 12'h600, 32'h0,        32'h00000008, 4'd5},  // R5
        {1'b0, 2'd2, 12'h604, 32'h0,        32'h1E1E1E1E, 4'd5},  // R5
        {1'b1, 2'd2, 12'h604, 32'hBEBEBEBE, 32'h0,        4'd6},  // R6
        {1'b0, 2'd2, 12'h604, 32'h0,        32'hBEBEBEBE, 4'd6},  // R6
        {1'b1, 2'd2, 12'h604, 32'h12345678, 32'h0,        4'd6},  // R6
        {1'b0, 2'd2, 12'h604, 32'h0,        32'hBEBEBEBE, 4'd6},  // R6
        {1'b1, 2'd2, 12'h604, 32'h1E1E1E1E, 32'h0,        4'd6},  // R6
        {1'b0, 2'd2, 12'h604, 32'h0,        32'h1E1E1E1E, 4'd6},  // R6
        {1'b0, 2'd2, 12'h602, 32'h0,        32'h0,        4'd7},  // R7
        {1'b0, 2'd0, 12'h700, 32'h0,        32'h0,        4'd8},  // R8
        {1'b0, 2'd2, 12'h404, 32'h0,        32'h0,        4'd8}   // R8
    };

    initial begin : wdog
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int lat, w0, e0;
        for (int i = 0; i < 64; i++) port_mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) ext_mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(10, "rvalid after reset", 32'(bus_rvalid), 32'h0);
        chk(10, "busy after reset", 32'(bus_busy), 32'h0);
        chk(10, "big_endian after reset", 32'(big_endian), 32'h0);
        chk(10, "rdata after reset", bus_rdata, 32'h0);
        chk(11, "rev_id with bank", 32'(rev_id), 32'd2); // R11

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][82]) begin
                bus_write(VEC[i][81:80], VEC[i][79:68], VEC[i][67:36]);
            end else begin
                bus_read(VEC[i][81:80], VEC[i][79:68], rd, lat);
                chk(int'(VEC[i][3:0]), $sformatf("vector %0d read", i), rd, VEC[i][35:4]);
                // R9 / R3: latency of the valid pulse
                chk((VEC[i][81:80] == 2'd1 && VEC[i][79:68] < 12'h420) ? 3 : 9,
                    $sformatf("vector %0d latency", i), 32'(lat),
                    (VEC[i][81:80] == 2'd1 && VEC[i][79:68] < 12'h420) ? 32'd2 : 32'd1);
            end
        end

        // R2: split write order into an index/data pair, busy in between
        w0 = wcnt;
        bus_write(2'd1, 12'h41A, 32'h00003344);
        @(negedge clk);
        chk(2, "busy during second byte", 32'(seen_busy), 32'h1);
        chk(2, "split write count", 32'(wcnt - w0), 32'd2);
        chk(2, "first port addr", 32'(wlog_addr[w0[3:0]]), 32'h3DA);
        chk(2, "first port data", 32'(wlog_data[w0[3:0]]), 32'h44);
        chk(2, "second port addr", 32'(wlog_addr[4'(w0 + 1)]), 32'h3DB);
        chk(2, "second port data", 32'(wlog_data[4'(w0 + 1)]), 32'h33);

        // R1: byte write to the last port of the bank
        bus_write(2'd0, 12'h41F, 32'hFFFFFF9C);
        bus_read(2'd0, 12'h41F, rd, lat);
        chk(1, "last port byte", rd, 32'h9C);

        // R4: top register index 10 at offset 0x514
        bus_write(2'd2, 12'h514, 32'hFFFF1234);
        bus_read(2'd0, 12'h515, rd, lat);
        chk(4, "register 10", rd, 32'h1234);

        // R8: writes to unmapped offsets and word writes to legacy produce no strobe
        w0 = wcnt; e0 = ecnt;
        bus_write(2'd1, 12'h450, 32'h0000ABCD);
        bus_write(2'd1, 12'h516, 32'h0000ABCD);
        bus_write(2'd2, 12'h408, 32'hBEBEBEBE);
        bus_write(2'd2, 12'hFFC, 32'hBEBEBEBE);
        @(negedge clk);
        chk(8, "port writes after dropped", 32'(wcnt - w0), 32'd0);
        chk(8, "reg writes after dropped", 32'(ecnt - e0), 32'd0);
        chk(8, "big_endian after dropped", 32'(big_endian), 32'h0);

        // R6: set the flag, then near misses must keep it set
        bus_write(2'd2, 12'h604, 32'hBEBEBEBE);
        chk(6, "flag set", 32'(big_endian), 32'h1);
        bus_write(2'd1, 12'h604, 32'h1E1E1E1E);
        chk(6, "halfword magic ignored", 32'(big_endian), 32'h1);
        bus_write(2'd2, 12'h604, 32'h1E1E1E1F);
        chk(6, "near miss ignored", 32'(big_endian), 32'h1);
        // R7: hole offsets do not touch the flag
        bus_write(2'd2, 12'h600, 32'h1E1E1E1E);
        bus_write(2'd2, 12'h606, 32'h1E1E1E1E);
        chk(7, "hole write ignored", 32'(big_endian), 32'h1);
        bus_read(2'd2, 12'h607, rd, lat);
        chk(7, "hole read", rd, 32'h0);
        bus_read(2'd2, 12'h600, rd, lat);
        chk(5, "length reads 8 after hole write", rd, 32'h8);
        bus_read(2'd1, 12'h604, rd, lat);
        chk(5, "halfword read of order reg", rd, 32'h0);

        // R11: instance without the bank
        chk(11, "rev_id without bank", 32'(n_rev), 32'd1);
        bus_read(2'd2, 12'h604, rd, lat);
        chk(11, "order reg absent reads 0", n_rdata, 32'h0);
        chk(11, "absent bank flag", 32'(n_be), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule